// File: doc/BRIEF.md
# Serial Register Port with Motion Burst

This block is a four-wire serial slave. A host microcontroller uses it to reach a bank of 8-bit registers that neighbouring logic holds. Each transaction is two bytes. The first byte carries the direction in its top bit and a 7-bit register address. The second byte carries the data, either from the host or back to it. The block samples MOSI and watches SCLK and chip select in its own system clock domain, through a small synchroniser and an edge detector. The system clock must run at least eight times faster than SCLK.

The block answers the identification addresses itself. For every other register it drives an address and a one-cycle read or write strobe to the neighbour, which returns the read data combinationally. Reading the burst address streams seven motion registers back-to-back, with no address byte between them. After the burst, the port sends zeros and ignores the host until chip select rises. Writing the magic value to the reset address raises a one-cycle soft reset pulse; the neighbour uses it to restore its defaults. Raising chip select at any point discards the transaction in flight.

The controller has six states: `ST_IDLE`, `ST_ADDR`, `ST_FETCH`, `ST_SEND`, `ST_RECV` and `ST_BURST`. Its transitions are:
- Chip select low: `ST_IDLE` → `ST_ADDR`.
- Eighth address bit with the top bit at 1: `ST_ADDR` → `ST_RECV`.
- Eighth address bit with the top bit at 0: `ST_ADDR` → `ST_FETCH`.
- After one cycle: `ST_FETCH` → `ST_SEND`, or `ST_FETCH` → `ST_BURST` during a burst.
- Eighth data bit: `ST_SEND` → `ST_ADDR` and `ST_RECV` → `ST_ADDR`.
- Eighth bit of a burst byte while bytes remain: `ST_BURST` → `ST_FETCH`.
- Chip select high: any state → `ST_IDLE`.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, with chip select high, MISO is high-Z and none of `reg_rd`, `reg_wr` or `soft_rst` pulses.
- R2: An address byte with bit 7 = 1, followed by a data byte, gives exactly one `reg_wr` pulse. During that pulse, `reg_addr` holds the 7-bit address and `reg_wdata` holds the data byte. Both bytes are sent MSB first. The writable addresses are 0x02, 0x0B, 0x10, 0x11 and 0x2E.
- R3: An address byte with bit 7 = 0 at a neighbour address (0x02 to 0x11, or 0x2E) gives one `reg_rd` pulse with that address. The value of `reg_rdata` is then returned MSB first in the next byte. MISO changes after falling SCLK and is sampled on rising SCLK.
- R4: Address 0x00 reads 0x0D, 0x01 reads 0x02, 0x3E reads 0xFD and 0x3F reads 0xF2. These reads give no `reg_rd` pulse.
- R5: A read of any other address (not 0x42) returns 0x00 and gives no `reg_rd` pulse.
- R6: A write to an address that is not writable gives no `reg_wr` pulse.
- R7: While chip select is high, MISO is high-Z and SCLK and MOSI activity has no effect.
- R8: Raising chip select partway through a transaction discards it with no strobe. The next transaction starts again from bit 0.
- R9: A read of 0x42 starts a burst. The burst returns the neighbour values at 0x02, 0x03, 0x04, 0x05, 0x06, 0x07 and 0x08, in that order, with one `reg_rd` pulse for each byte.
- R10: Once the seventh burst byte has been sent, MISO sends zeros. Until chip select rises, incoming bytes give no strobe.
- R11: Writing 0x5A to 0x3A gives one `soft_rst` pulse and no `reg_wr` pulse. Writing any other value to 0x3A has no effect.
- R12: Transactions that follow each other in one chip-select frame, outside a burst, each complete normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| ncs | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, high-Z while ncs is high |
| reg_addr | output | 7 | Register address presented to the neighbour |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data from the neighbour for reg_addr |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data for reg_addr |
| soft_rst | output | 1 | One-cycle pulse after the magic reset write |

## Verification
The assertions rely on SCLK, MOSI and chip select being slow compared with the system clock. Each SCLK phase must last several system cycles, so that a byte boundary's strobe can never fall in the same cycle as another byte boundary. The bench holds each SCLK phase for eight system clocks and changes MOSI only while SCLK is low. It changes chip select only while SCLK is low, so every edge the synchroniser sees is clean. A behavioural model of the neighbour's read data, together with logs of the strobes, gives the expected values for every transaction.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_PROD      = 7'h00;
    localparam logic [ADDR_W-1:0] A_REV       = 7'h01;
    localparam logic [ADDR_W-1:0] A_REV_INV   = 7'h3E;
    localparam logic [ADDR_W-1:0] A_PROD_INV  = 7'h3F;
    localparam logic [ADDR_W-1:0] A_SOFT_RST  = 7'h3A;
    localparam logic [ADDR_W-1:0] A_BURST     = 7'h42;
    localparam logic [ADDR_W-1:0] A_BURST_1ST = 7'h02;

    localparam logic [DATA_W-1:0] V_PROD      = 8'h0D;
    localparam logic [DATA_W-1:0] V_REV       = 8'h02;
    localparam logic [DATA_W-1:0] V_REV_INV   = 8'hFD;
    localparam logic [DATA_W-1:0] V_PROD_INV  = 8'hF2;
    localparam logic [DATA_W-1:0] V_MAGIC     = 8'h5A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FETCH,
        ST_SEND,
        ST_RECV,
        ST_BURST
    } port_state_e;

    // Registers that live in the neighbouring logic.
    function automatic logic is_nbr(input logic [ADDR_W-1:0] a);
        return ((a >= 7'h02) && (a <= 7'h11)) || (a == 7'h2E);
    endfunction

    // Neighbour registers that accept writes.
    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        return (a == 7'h02) || (a == 7'h0B) || (a == 7'h10) ||
               (a == 7'h11) || (a == 7'h2E);
    endfunction

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic ncs,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic ncs_hi,
    output logic mosi_s
);
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] ncs_p;
    logic [STAGES-1:0] mosi_p;
    logic              sclk_d;

    // SCLK, MOSI and NCS go through equal-length chains, so they stay aligned.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_p <= '0;
                    ncs_p  <= '1;
                    mosi_p <= '0;
                end else begin
                    sclk_p <= sclk;
                    ncs_p  <= ncs;
                    mosi_p <= mosi;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_p <= '0;
                    ncs_p  <= '1;
                    mosi_p <= '0;
                end else begin
                    sclk_p <= {sclk_p[STAGES-2:0], sclk};
                    ncs_p  <= {ncs_p[STAGES-2:0], ncs};
                    mosi_p <= {mosi_p[STAGES-2:0], mosi};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_p[STAGES-1];
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
    assign ncs_hi    = ncs_p[STAGES-1];
    assign mosi_s    = mosi_p[STAGES-1];

endmodule

// File: rtl/spi_rd_mux.sv
module spi_rd_mux
    import spi_slv_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] nbr_data,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        if (addr == A_PROD)           rd_data = V_PROD;
        else if (addr == A_REV)       rd_data = V_REV;
        else if (addr == A_REV_INV)   rd_data = V_REV_INV;
        else if (addr == A_PROD_INV)  rd_data = V_PROD_INV;
        else if (is_nbr(addr))        rd_data = nbr_data;
        else                          rd_data = '0;
    end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         shift,
    output logic         bit_o
);
    logic [W-1:0] tx_q;
    logic         out_q;

    // A load waits for the next falling edge; each falling edge presents one bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            out_q <= 1'b0;
        end else if (clr) begin
            tx_q  <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            tx_q  <= ld_data;
        end else if (shift) begin
            out_q <= tx_q[W-1];
            tx_q  <= {tx_q[W-2:0], 1'b0};
        end
    end

    assign bit_o = out_q;

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BURST_LEN   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              ncs,
    input  logic              mosi,
    output logic              miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              soft_rst
);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int BIDX_W = $clog2(BURST_LEN + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [BIDX_W-1:0] LAST_BIDX = BIDX_W'(BURST_LEN - 1);

    port_state_e       state, state_n;
    logic              sclk_rise, sclk_fall, ncs_hi, mosi_s;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] rx_byte;
    logic [CNT_W-1:0]  bit_cnt;
    logic              last_bit;
    logic              byte_done;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_q;
    logic [BIDX_W-1:0] bidx_q;
    logic              rd_q, wr_q, rst_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] fetch_data;
    logic              tx_bit;
    logic              shifting;

    spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .ncs       (ncs),
        .mosi      (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .ncs_hi    (ncs_hi),
        .mosi_s    (mosi_s)
    );

    spi_rd_mux u_mux (
        .addr     (addr_q),
        .nbr_data (reg_rdata),
        .rd_data  (fetch_data)
    );

    spi_tx_shift #(.W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ncs_hi),
        .load    (state == ST_FETCH),
        .ld_data (fetch_data),
        .shift   (sclk_fall),
        .bit_o   (tx_bit)
    );

    assign rx_byte   = {sh_q[DATA_W-2:0], mosi_s};
    assign last_bit  = (bit_cnt == LAST_BIT);
    assign byte_done = sclk_rise && last_bit;
    assign shifting  = (state == ST_ADDR) || (state == ST_SEND) ||
                       (state == ST_RECV) || (state == ST_BURST);

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (!ncs_hi) state_n = ST_ADDR;
            ST_ADDR:  if (byte_done) state_n = rx_byte[DATA_W-1] ? ST_RECV : ST_FETCH;
            ST_FETCH: state_n = burst_q ? ST_BURST : ST_SEND;
            ST_SEND:  if (byte_done) state_n = ST_ADDR;
            ST_RECV:  if (byte_done) state_n = ST_ADDR;
            ST_BURST: if (byte_done && (bidx_q < LAST_BIDX)) state_n = ST_FETCH;
            default:  state_n = ST_IDLE;
        endcase
        if (ncs_hi) state_n = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_cnt <= '0;
            addr_q  <= '0;
            burst_q <= 1'b0;
            bidx_q  <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            rst_q   <= 1'b0;
            wdata_q <= '0;
        end else begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            rst_q <= 1'b0;
            if (ncs_hi) begin
                bit_cnt <= '0;
                burst_q <= 1'b0;
                bidx_q  <= '0;
            end else begin
                if (sclk_rise && shifting) begin
                    sh_q    <= rx_byte;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                unique case (state)
                    ST_ADDR: begin
                        if (byte_done) begin
                            if (!rx_byte[DATA_W-1] && (rx_byte[ADDR_W-1:0] == A_BURST)) begin
                                addr_q  <= A_BURST_1ST;
                                burst_q <= 1'b1;
                                bidx_q  <= '0;
                            end else begin
                                addr_q  <= rx_byte[ADDR_W-1:0];
                            end
                        end
                    end
                    ST_FETCH: rd_q <= is_nbr(addr_q);
                    ST_RECV: begin
                        if (byte_done) begin
                            wdata_q <= rx_byte;
                            wr_q    <= is_writable(addr_q);
                            rst_q   <= (addr_q == A_SOFT_RST) && (rx_byte == V_MAGIC);
                        end
                    end
                    ST_BURST: begin
                        if (byte_done && (bidx_q < LAST_BIDX)) begin
                            bidx_q <= bidx_q + 1'b1;
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign miso      = ncs ? 1'bz : tx_bit;
    assign reg_addr  = addr_q;
    assign reg_rd    = rd_q;
    assign reg_wr    = wr_q;
    assign reg_wdata = wdata_q;
    assign soft_rst  = rst_q;

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
    import spi_slv_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              soft_rst
);
    assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    assert_rd_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> is_nbr(reg_addr));

    assert_wr_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> is_writable(reg_addr));

    assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_rst_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (!reg_wr && (reg_addr == A_SOFT_RST)));

    assert_rst_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .soft_rst (soft_rst)
);

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       ncs = 1'b1;
    logic       mosi = 1'b0;
    wire        miso;
    logic [6:0] reg_addr;
    logic       reg_rd, reg_wr, soft_rst;
    logic [7:0] reg_rdata, reg_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    int         wr_cnt = 0, rd_cnt = 0, rst_cnt = 0;
    logic [6:0] lw_addr;
    logic [7:0] lw_data;
    logic [6:0] rd_log[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural neighbour: read data as a function of the address.
    function automatic logic [7:0] nbr_val(input logic [6:0] a);
        return 8'(a * 13 + 71);
    endfunction
    assign reg_rdata = nbr_val(reg_addr);

    spi_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ncs(ncs), .mosi(mosi),
        .miso(miso), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .soft_rst(soft_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Strobe logs, taken on every clock.
    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin wr_cnt++; lw_addr = reg_addr; lw_data = reg_wdata; end
            if (reg_rd) begin rd_cnt++; rd_log.push_back(reg_addr); end
            if (soft_rst) rst_cnt++;
        end
    end

    // R7 / R1: per-clock check of MISO while chip select is high.
    always @(negedge clk) begin
        if (live && ncs === 1'b1)
            chk(miso === 1'bz, "R7 miso hi-z", int'(miso), 0);
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] o, input int n, output logic [7:0] i);
        i = 8'h00;
        for (int b = 0; b < n; b++) begin
            mosi = o[7-b];
            wait_clk(HALF_SCLK);
            i = {i[6:0], miso};
            sclk = 1'b1;
            wait_clk(HALF_SCLK);
            sclk = 1'b0;
        end
    endtask

    task automatic frame_on();  ncs = 1'b0; wait_clk(HALF_SCLK); endtask
    task automatic frame_off(); wait_clk(HALF_SCLK); ncs = 1'b1; wait_clk(2*HALF_SCLK); endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] d);
        logic [7:0] junk;
        frame_on();
        xfer({1'b0, a}, 8, junk);
        xfer(8'h00, 8, d);
        frame_off();
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] junk;
        frame_on();
        xfer({1'b1, a}, 8, junk);
        xfer(d, 8, junk);
        frame_off();
    endtask

    task automatic read_chk(input logic [6:0] a, input logic [7:0] exp, input bit nbr, input string req);
        logic [7:0] d;
        int rc;
        rc = rd_cnt;
        do_read(a, d);
        chk(d === exp, req, int'(d), int'(exp));
        chk(rd_cnt == rc + (nbr ? 1 : 0), {req, " rd strobe count"}, rd_cnt - rc, nbr ? 1 : 0);
        if (nbr && rd_log.size() > 0)
            chk(rd_log[$] == a, {req, " rd addr"}, int'(rd_log[$]), int'(a));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int wc, rc, sc;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        live = 1'b1;

        // R1: reset state
        chk(miso === 1'bz, "R1 miso after reset", int'(miso), 0);
        chk(wr_cnt == 0 && rd_cnt == 0 && rst_cnt == 0, "R1 no strobes", wr_cnt + rd_cnt + rst_cnt, 0);

        // R4: identification values
        read_chk(7'h00, 8'h0D, 1'b0, "R4 id0");
        read_chk(7'h01, 8'h02, 1'b0, "R4 id1");
        read_chk(7'h3E, 8'hFD, 1'b0, "R4 id3e");
        read_chk(7'h3F, 8'hF2, 1'b0, "R4 id3f");

        // R3: neighbour reads
        read_chk(7'h05, nbr_val(7'h05), 1'b1, "R3 rd05");
        read_chk(7'h11, nbr_val(7'h11), 1'b1, "R3 rd11");
        read_chk(7'h2E, nbr_val(7'h2E), 1'b1, "R3 rd2e");

        // R5: unmapped reads
        read_chk(7'h20, 8'h00, 1'b0, "R5 rd20");
        read_chk(7'h7F, 8'h00, 1'b0, "R5 rd7f");

        // R2: write
        wc = wr_cnt;
        do_write(7'h11, 8'hA7);
        chk(wr_cnt == wc + 1, "R2 wr count", wr_cnt - wc, 1);
        chk(lw_addr == 7'h11, "R2 wr addr", int'(lw_addr), 'h11);
        chk(lw_data == 8'hA7, "R2 wr data", int'(lw_data), 'hA7);

        // R6: read-only targets ignored
        wc = wr_cnt;
        do_write(7'h05, 8'hFF);
        do_write(7'h00, 8'h12);
        chk(wr_cnt == wc, "R6 ro write ignored", wr_cnt - wc, 0);

        // R11: magic reset
        wc = wr_cnt; sc = rst_cnt;
        do_write(7'h3A, 8'h5A);
        chk(rst_cnt == sc + 1, "R11 soft reset pulse", rst_cnt - sc, 1);
        chk(wr_cnt == wc, "R11 no write strobe", wr_cnt - wc, 0);
        do_write(7'h3A, 8'h11);
        chk(rst_cnt == sc + 1, "R11 wrong value ignored", rst_cnt - sc, 1);

        // R7: activity with chip select high
        wc = wr_cnt; rc = rd_cnt;
        xfer(8'h91, 8, d);
        xfer(8'h3C, 8, d);
        chk(wr_cnt == wc && rd_cnt == rc, "R7 ignored while deselected", wr_cnt + rd_cnt - wc - rc, 0);
        read_chk(7'h01, 8'h02, 1'b0, "R7 port intact");

        // R8: aborts in address and in data phase
        wc = wr_cnt;
        frame_on(); xfer(8'h91, 4, d); frame_off();
        frame_on(); xfer(8'h91, 8, d); xfer(8'h66, 5, d); frame_off();
        chk(wr_cnt == wc, "R8 aborted no strobe", wr_cnt - wc, 0);
        do_write(7'h2E, 8'h33);
        chk(wr_cnt == wc + 1 && lw_addr == 7'h2E && lw_data == 8'h33, "R8 next write",
            int'(lw_data), 'h33);

        // R9 / R10: burst
        rd_log.delete();
        rc = rd_cnt; wc = wr_cnt;
        frame_on();
        xfer(8'h42, 8, d);
        for (int k = 0; k < 7; k++) begin
            xfer(8'h00, 8, d);
            chk(d === nbr_val(7'(2 + k)), "R9 burst byte", int'(d), int'(nbr_val(7'(2 + k))));
        end
        chk(rd_cnt == rc + 7, "R9 burst strobes", rd_cnt - rc, 7);
        for (int k = 0; k < 7; k++) begin
            if (rd_log.size() > k)
                chk(rd_log[k] == 7'(2 + k), "R9 burst order", int'(rd_log[k]), 2 + k);
        end
        xfer(8'h91, 8, d);
        chk(d === 8'h00, "R10 zeros after burst", int'(d), 0);
        xfer(8'h55, 8, d);
        chk(d === 8'h00, "R10 zeros after burst", int'(d), 0);
        xfer(8'h00, 8, d);
        xfer(8'h00, 8, d);
        chk(rd_cnt == rc + 7 && wr_cnt == wc, "R10 port locked", rd_cnt - rc, 7);
        frame_off();
        read_chk(7'h3F, 8'hF2, 1'b0, "R10 unlocked after frame");

        // R12: back-to-back in one frame
        rc = rd_cnt;
        frame_on();
        xfer(8'h01, 8, d);
        xfer(8'h00, 8, d);
        chk(d === 8'h02, "R12 first read", int'(d), 'h02);
        xfer(8'h07, 8, d);
        xfer(8'h00, 8, d);
        chk(d === nbr_val(7'h07), "R12 second read", int'(d), int'(nbr_val(7'h07)));
        frame_off();
        chk(rd_cnt == rc + 1, "R12 strobe count", rd_cnt - rc, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule